// File: doc/BRIEF.md
# Memory-Port Hazard Scheduler for a Five-Stage Pipeline

This block is the issue and stall controller of a five-stage in-order pipeline. Its stages are fetch, decode, operand fetch, execute and result store. Fetch, operand fetch and store each need one memory access per instruction. Decode and execute never touch memory. Every cycle the block decides which of the pending accesses get a port. A stage that cannot finish holds its instruction, and the stage after it receives a bubble. No datapath, decoding, data or control hazards and no real memory are modelled: an access is one granted cycle.

A two-bit mode input selects the memory organisation. The choices are:
- one shared bus;
- one shared bus where each fetch access returns two consecutive instructions;
- a private instruction port plus one data port shared by operand fetch and store;
- a private port for each of the three stages.

The mode is taken only while the pipeline is empty. A different mode presented while instructions are in flight is flagged and has no effect. Instructions enter with a tag, leave in order with that tag, and are counted as they retire.

Top module: `memport_hazard_sched`

## Requirements
- R1: An instruction is accepted into fetch when `in_valid` is high and the fetch slot is empty or advancing. Each unstalled stage hands its instruction to the next stage in one cycle. The execute stage always advances. Tags retire in acceptance order, and `ret_tag` shows the store-stage tag while `gnt[2]` is high.
- R2: A valid store-stage instruction is always granted and retires in that cycle. `retired` increments by one at that edge and at no other.
- R3: `gnt` bit 0 is fetch, bit 1 is operand fetch and bit 2 is store. On a shared port the store wins over operand fetch, and operand fetch wins over fetch. A grant is given only to a stage that can advance.
- R4: `stage_stall` bit i (0 = fetch to 4 = store) is high when stage i holds a valid instruction that does not advance. A stalled stage keeps its tag, and a bubble enters the stage after it.
- R5: Mode 2'b00 (one bus): at most one grant per cycle. With continuous input, 20 instructions retire in every 60 cycles of steady state.
- R6: Mode 2'b01 (paired fetch): a fetch access brings two instructions. The second one, or an early fetch of the next pair made on an idle bus cycle, needs no grant when it issues. At most one grant per cycle. With continuous input, 24 instructions retire per 60 cycles.
- R7: Mode 2'b10 (split): fetch has its own port, and operand fetch and store are never granted together. With continuous input, 30 instructions retire per 60 cycles.
- R8: Mode 2'b11 (three ports): no stage ever stalls, and 60 instructions retire per 60 cycles. Starting from empty, the first store grant comes 4 cycles after the first fetch grant.
- R9: `mode_in` is loaded only at an edge where all stages are empty. While any stage is valid, `mode_ignored` is high exactly when `mode_in` differs from the active mode, and the schedule follows the active mode.
- R10: During reset all stage valids, stalls and grants are 0, `retired` is 0, and the active mode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new instruction is offered |
| in_tag | input | TAG_W | Tag of the offered instruction |
| mode_in | input | 2 | Requested memory organisation |
| stage_valid | output | 5 | Occupancy per stage, bit 0 fetch to bit 4 store |
| stage_stall | output | 5 | Valid and not advancing, per stage |
| gnt | output | 3 | Port grants: bit 0 fetch, bit 1 operand, bit 2 store |
| ret_tag | output | TAG_W | Tag in the store stage |
| retired | output | CNT_W | Count of retired instructions |
| mode_ignored | output | 1 | `mode_in` differs from the active mode while busy |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume that `in_valid`, `in_tag` and `mode_in` are known and stable around each rising edge. Changes to `mode_in` are allowed in any cycle, because the block must tolerate them.

The stimulus drives every input on the falling edge only. It holds reset for several cycles. It changes `mode_in` both on an empty pipeline and in mid-flight, including a stretch inside a rate window. Offers are sometimes continuous and sometimes gapped.

// File: rtl/memport_hazard_sched.sv
module memport_hazard_sched #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [1:0]       mode_in,
  output logic [4:0]       stage_valid,
  output logic [4:0]       stage_stall,
  output logic [2:0]       gnt,
  output logic [TAG_W-1:0] ret_tag,
  output logic [CNT_W-1:0] retired,
  output logic             mode_ignored
);
  localparam int NST = 5;
  localparam int SF = 0, SD = 1, SO = 2, SX = 3, SR = 4;
  localparam logic [1:0] M_BUS = 2'd0, M_PAIR = 2'd1, M_SPLIT = 2'd2, M_MULTI = 2'd3;

  logic [NST-1:0]   v, adv;
  logic [TAG_W-1:0] tag_q [NST];
  logic [1:0]       mode_q, k_q, k_d;
  logic [CNT_W-1:0] cnt_q;
  logic empty, shared_bus, fetch_free, f_need, f_room, adv_d, adv_f;
  logic g_f, g_o, g_s, pf, take;

  assign empty      = ~|v;
  assign shared_bus = (mode_q == M_BUS) || (mode_q == M_PAIR);

  assign g_s   = v[SR];
  assign g_o   = v[SO] && ((mode_q == M_MULTI) || !v[SR]);
  assign adv_d = v[SD] && (!v[SO] || g_o);

  assign fetch_free = !shared_bus || !(v[SR] || v[SO]);
  assign f_need     = v[SF] && !((mode_q == M_PAIR) && (k_q != 2'd0));
  assign f_room     = v[SF] && (!v[SD] || adv_d);
  assign g_f        = f_need && f_room && fetch_free;
  assign adv_f      = f_room && (!f_need || g_f);
  assign pf         = (mode_q == M_PAIR) && f_room && !f_need && (k_q == 2'd1) && fetch_free;
  assign take       = in_valid && (!v[SF] || adv_f);

  assign adv = {v[SR], v[SX], g_o, adv_d, adv_f};

  assign stage_valid  = v;
  assign stage_stall  = v & ~adv;
  assign gnt          = {g_s, g_o, g_f | pf};
  assign ret_tag      = tag_q[SR];
  assign retired      = cnt_q;
  assign mode_ignored = !empty && (mode_in != mode_q);

  always_comb begin
    k_d = k_q;
    if (mode_q == M_PAIR) begin
      if (g_f) k_d = 2'd1;
      else begin
        if (adv_f) k_d = k_d - 2'd1;
        if (pf)    k_d = k_d + 2'd2;
      end
    end
    if (empty && (mode_in != mode_q)) k_d = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v      <= '0;
      mode_q <= M_BUS;
      k_q    <= 2'd0;
      cnt_q  <= '0;
      for (int i = 0; i < NST; i++) tag_q[i] <= '0;
    end else begin
      v[SF] <= (v[SF] && !adv_f) || take;
      if (take) tag_q[SF] <= in_tag;
      for (int i = 1; i < NST; i++) begin
        v[i] <= adv[i-1] || (v[i] && !adv[i]);
        if (adv[i-1]) tag_q[i] <= tag_q[i-1];
      end
      if (v[SR]) cnt_q <= cnt_q + CNT_W'(1);
      if (empty) mode_q <= mode_in;
      k_q <= k_d;
    end
  end

  // R5 R6
  one_bus_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shared_bus |-> $onehot0(gnt));
  // R7
  data_port_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SPLIT) |-> !(gnt[1] && gnt[2]));
  // R8
  multi_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_MULTI) |-> (stage_stall == '0));
  // R3
  store_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_bus && stage_valid[SR]) |-> (gnt[1:0] == 2'b00));
  // R2
  retire_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[SR] |=> (retired == $past(retired) + CNT_W'(1)));
  // R2
  retire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_valid[SR] |=> $stable(retired));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_stall[SO] |=> (stage_valid[SO] && tag_q[SO] == $past(tag_q[SO])));
  // R1
  exec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[SX] |=> (stage_valid[SR] && ret_tag == $past(tag_q[SX])));
  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |=> (mode_q == $past(mode_q)));
endmodule

// File: tb/memport_hazard_sched_bench.sv
module memport_hazard_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int CW = 32;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic [1:0] mode_in = 2'd0;
  logic [4:0] stage_valid, stage_stall;
  logic [2:0] gnt;
  logic [TW-1:0] ret_tag;
  logic [CW-1:0] retired;
  logic mode_ignored;

  int nchk = 0, nfail = 0;
  int occ[5];
  int km = 0, mcur = 0, mcnt = 0, next_tag = 0;
  int tagq[$];

  memport_hazard_sched #(.TAG_W(TW), .CNT_W(CW)) u_memport_hazard_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag), .mode_in(mode_in),
    .stage_valid(stage_valid), .stage_stall(stage_stall), .gnt(gnt), .ret_tag(ret_tag),
    .retired(retired), .mode_ignored(mode_ignored));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit iv, input logic [1:0] mi);
    bit e_st, e_op, de_adv, fneed, room, ffree, e_f, pf, fadv, tk;
    int any;
    logic [4:0] ev, es;
    logic [2:0] eg;
    int n0, n1, n2, n3, n4;
    @(negedge clk);
    in_valid = iv;
    mode_in = mi;
    in_tag = TW'(next_tag);
    #1;
    any = 0;
    foreach (occ[i]) if (occ[i] >= 0) any++;
    e_st   = occ[4] >= 0;
    e_op   = occ[2] >= 0 && (mcur == 3 || !e_st);
    de_adv = occ[1] >= 0 && (occ[2] < 0 || e_op);
    fneed  = occ[0] >= 0 && !(mcur == 1 && km > 0);
    room   = occ[0] >= 0 && (occ[1] < 0 || de_adv);
    ffree  = mcur >= 2 || (occ[4] < 0 && occ[2] < 0);
    e_f    = fneed && room && ffree;
    fadv   = room && (!fneed || e_f);
    pf     = mcur == 1 && room && !fneed && km == 1 && ffree;
    tk     = iv && (occ[0] < 0 || fadv);
    for (int i = 0; i < 5; i++) ev[i] = occ[i] >= 0;
    es = {1'b0, 1'b0, occ[2] >= 0 && !e_op, occ[1] >= 0 && !de_adv, occ[0] >= 0 && !fadv};
    eg = {e_st, e_op, e_f | pf};
    chk(stage_valid == ev, "R1 stage valid", stage_valid, ev);
    chk(stage_stall == es, "R4 stall", stage_stall, es);
    chk(gnt == eg, "R3 grants", gnt, eg);
    chk(retired == CW'(mcnt), "R2 retired count", retired, mcnt);
    chk(mode_ignored == (any != 0 && int'(mi) != mcur), "R9 mode ignored flag", mode_ignored, any != 0 && int'(mi) != mcur);
    if (mcur < 2) chk($countones(gnt) <= 1, mcur == 0 ? "R5 single grant" : "R6 single grant", $countones(gnt), 1);
    if (mcur == 2) chk(!(gnt[1] && gnt[2]), "R7 data port shared", gnt, 3'b011);
    if (mcur == 3) chk(stage_stall == 5'd0, "R8 no stall", stage_stall, 0);
    if (e_st) begin
      int front;
      front = tagq.pop_front();
      chk(ret_tag == TW'(front), "R1 retire order", ret_tag, front & 255);
      mcnt++;
    end
    n4 = occ[3];
    n3 = e_op ? occ[2] : -1;
    n2 = de_adv ? occ[1] : (e_op ? -1 : occ[2]);
    n1 = fadv ? occ[0] : (de_adv ? -1 : occ[1]);
    n0 = tk ? next_tag : (fadv ? -1 : occ[0]);
    if (tk) begin
      tagq.push_back(next_tag);
      next_tag = (next_tag + 1) & 255;
    end
    if (mcur == 1) begin
      if (e_f) km = 1;
      else begin
        if (fadv) km = km - 1;
        if (pf) km = km + 2;
      end
    end
    if (any == 0) begin
      if (int'(mi) != mcur) km = 0;
      mcur = int'(mi);
    end
    occ[0] = n0; occ[1] = n1; occ[2] = n2; occ[3] = n3; occ[4] = n4;
  endtask

  task automatic rate_run(input logic [1:0] m, input int exp_cnt, input string req);
    longint c40, c100;
    int first_f, first_s;
    first_f = -1; first_s = -1; c40 = 0; c100 = 0;
    for (int c = 0; c < 15; c++) step(1'b0, m);
    for (int c = 0; c <= 100; c++) begin
      logic [1:0] mm;
      mm = (m == 2'd0 && c >= 50 && c < 70) ? 2'd3 : m;
      step(1'b1, mm);
      if (first_f < 0 && gnt[0]) first_f = c;
      if (first_s < 0 && gnt[2]) first_s = c;
      if (c == 40) c40 = retired;
      if (c == 100) c100 = retired;
    end
    chk(c100 - c40 == exp_cnt, req, c100 - c40, exp_cnt);
    if (m == 2'd3) chk(first_s - first_f == 4, "R8 fill latency", first_s - first_f, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    foreach (occ[i]) occ[i] = -1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(stage_valid == 5'd0, "R10 reset valid", stage_valid, 0);
    chk(stage_stall == 5'd0, "R10 reset stall", stage_stall, 0);
    chk(gnt == 3'd0, "R10 reset grants", gnt, 0);
    chk(retired == '0, "R10 reset count", retired, 0);
    chk(mode_ignored == 1'b0, "R10 reset flag", mode_ignored, 0);
    rst_n = 1'b1;
    rate_run(2'd0, 20, "R5 one-bus rate");
    rate_run(2'd1, 24, "R6 paired-fetch rate");
    rate_run(2'd2, 30, "R7 split rate");
    rate_run(2'd3, 60, "R8 three-port rate");
    begin
      logic [1:0] m;
      m = 2'd0;
      for (int c = 0; c < 3000; c++) begin
        if ($urandom_range(0, 24) == 0) m = 2'($urandom_range(0, 3));
        step((c % 200) < 150 ? ($urandom_range(0, 3) != 0) : 1'b0, m);
      end
    end
    for (int c = 0; c < 15; c++) step(1'b0, 2'd0);
    chk(tagq.size() == 0, "R1 all drained", tagq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule